// File: doc/BRIEF.md
# SMBus Target Command Responder

This block is the byte-level half of an SMBus target. A bit-level I2C target engine in front of it handles the bus pins and reports events as one-cycle pulses: a start or repeated start, a stop, and an address match together with the direction bit. Received bytes arrive as a valid strobe, and the responder returns its ack or nack decision combinationally in the same cycle. Bytes to transmit are pulled through a valid/ready pair. After each transmitted byte the engine reports whether the host acknowledged it.

After a write-direction address, the first byte is a command. Command bits 7:6 select the kind of target:
- a byte register, indexed by bits 2:0;
- a word register, indexed by bits 1:0;
- a single block buffer.

Byte and word data are written into a staging area. Word data is low byte first. A block write sends a count byte first, then that many data bytes. The staged data is committed to storage only when a stop arrives, and a one-cycle strobe then reports the command and the number of data bytes committed.

On a read, the responder serves the register chosen by the most recent accepted command. That command may come from the same transaction, before a repeated start, or from an earlier one. Word reads are low byte first. Block reads begin with a count byte. Positions past the valid data read as 0xFF.

Back-pressure rules:
- On the receive side the responder never stalls, so no ready signal is needed. Its ack is valid in every cycle that `rx_valid` is high.
- On the transmit side the engine may hold `tx_ready` low for any number of cycles. While `tx_valid` is high and no bus event or host-ack report arrives, `tx_data` does not change.
- A byte is consumed in the cycle where `tx_valid` and `tx_ready` are both high.

Top module: `smbus_cmd_resp`

## Requirements
- R1: After reset, `tx_valid` and `wr_stb` are low, and every byte register, word register and the block count read as zero. The selected command is 0x00, so a plain read returns byte register 0.
- R2: Command decoding follows the rules below.
  - Command bits 7:6 = 00 select byte register bits 2:0, 01 select word register bits 1:0, and 10 select the block buffer.
  - A command with bits 7:6 = 11 is nacked. That transfer is discarded and the selected command stays unchanged.
  - A valid command is acked and becomes the selected command at once.
- R3: A byte-register write acks exactly one data byte. At a stop it commits that byte, and `wr_stb` is high in the cycle after the stop with `wr_cmd` equal to the command and `wr_len` = 1. A second data byte is nacked, and the whole transfer is then discarded.
- R4: A word write acks two data bytes, low byte first, and commits with `wr_len` = 2. A word read returns the low byte, then the high byte.
- R5: A block write acks its count byte only when the count is 1 to 32. It then acks exactly that many data bytes and commits with `wr_len` equal to the count. A count of 0 or above 32 is nacked, as is any byte past the count, and either case discards the transfer.
- R6: A write that reaches a stop before all its data bytes have arrived produces no strobe and leaves storage unchanged.
- R7: Storage changes only at a stop. A repeated start discards staged data but keeps the command selection.
- R8: A read that has no command byte before it returns the register chosen by the most recent accepted command, including a command sent alone before a repeated start.
- R9: A block read sends the count byte first, then the stored bytes in order. Any read position beyond the valid data, for every kind of register, returns 0xFF.
- R10: `tx_data` holds steady while `tx_valid` is high and `tx_ready` is low.
- R11: After the host nacks a byte, `tx_valid` stays low until the next address match.
- R12: A byte received when no write-direction address is active is nacked and has no effect on storage or selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | Start or repeated start seen (pulse) |
| bus_stop | input | 1 | Stop seen (pulse) |
| adr_hit | input | 1 | Own address matched (pulse) |
| adr_read | input | 1 | Direction bit with `adr_hit`, 1 = read |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | 8 | Received byte |
| rx_ack | output | 1 | Ack decision for the byte on `rx_data` |
| tx_ready | input | 1 | Engine wants the next byte |
| tx_valid | output | 1 | Responder offers a byte |
| tx_data | output | 8 | Byte to transmit |
| hack_valid | input | 1 | Host ack bit for the last byte sent is reported |
| hack_nack | input | 1 | With `hack_valid`: 1 = host nacked |
| wr_stb | output | 1 | Commit pulse |
| wr_cmd | output | 8 | Command of the committed write |
| wr_len | output | $clog2(BLK_MAX+1) (6) | Data bytes committed |

## Verification
The directed cases cover every boundary:
- block counts of 0, 1, 32 and 33, which separate the count check from the byte limit;
- a byte write with an extra byte and a word write with one byte missing, which separate nack-and-discard from a partial commit;
- a command followed only by a repeated start, which separates selection from storage update;
- a reserved command, which shows the selection is held.

Random transactions then mix all command kinds, random counts and lengths, short and long reads, plain reads and writes that end in a repeated start. This shows that commit timing, stored data and the 0xFF fill stay consistent across many sequences. A held-off `tx_ready` and a host nack check the transmit handshake itself.

// File: rtl/smbr_pkg.sv
package smbr_pkg;
  typedef enum logic [1:0] {
    K_BYTE  = 2'b00,
    K_WORD  = 2'b01,
    K_BLOCK = 2'b10,
    K_NONE  = 2'b11
  } cmd_kind_e;

  localparam logic [7:0] FILL_BYTE = 8'hFF;

  function automatic cmd_kind_e kind_of(input logic [7:0] c);
    return cmd_kind_e'(c[7:6]);
  endfunction
endpackage

// File: rtl/smbr_wr_path.sv
module smbr_wr_path
  import smbr_pkg::*;
#(
  parameter int BLK_MAX = 32,
  localparam int LW = $clog2(BLK_MAX + 1),
  localparam int CW = $clog2(BLK_MAX + 2),
  localparam int SW = $clog2(BLK_MAX)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_start,
  input  logic                    bus_stop,
  input  logic                    adr_hit,
  input  logic                    adr_read,
  input  logic                    rx_valid,
  input  logic [7:0]              rx_data,
  output logic                    rx_ack,
  output logic [7:0]              sel_cmd,
  output logic                    cmt_stb,
  output logic [7:0]              cmt_cmd,
  output logic [LW-1:0]           cmt_len,
  output logic [BLK_MAX-1:0][7:0] stage
);
  logic          wr_act, have_cmd, bad;
  logic [7:0]    cmd_q;
  logic [CW-1:0] cnt;
  logic [LW-1:0] blen;
  cmd_kind_e     kind;
  logic          len_ok, complete;
  logic [LW-1:0] done_len;
  logic [SW-1:0] slot;

  assign kind   = kind_of(cmd_q);
  assign len_ok = (rx_data != 8'd0) && (rx_data <= 8'(BLK_MAX));
  assign slot   = SW'((kind == K_BLOCK) ? cnt - CW'(1) : cnt);

  // ack decision for the byte currently offered
  always_comb begin
    rx_ack = 1'b0;
    if (wr_act && !bad) begin
      if (!have_cmd) rx_ack = (kind_of(rx_data) != K_NONE);
      else begin
        unique case (kind)
          K_BYTE:  rx_ack = (cnt == '0);
          K_WORD:  rx_ack = (cnt < CW'(2));
          K_BLOCK: rx_ack = (cnt == '0) ? len_ok : (cnt <= CW'(blen));
          default: rx_ack = 1'b0;
        endcase
      end
    end
  end

  always_comb begin
    complete = 1'b0;
    done_len = '0;
    unique case (kind)
      K_BYTE:  begin complete = (cnt == CW'(1)); done_len = LW'(1); end
      K_WORD:  begin complete = (cnt == CW'(2)); done_len = LW'(2); end
      K_BLOCK: begin complete = (cnt != '0) && (cnt == CW'(blen) + CW'(1)); done_len = blen; end
      default: begin complete = 1'b0; done_len = '0; end
    endcase
    complete = complete && have_cmd && !bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_act   <= 1'b0;
      have_cmd <= 1'b0;
      bad      <= 1'b0;
      cmd_q    <= '0;
      cnt      <= '0;
      blen     <= '0;
      sel_cmd  <= '0;
      cmt_stb  <= 1'b0;
      cmt_cmd  <= '0;
      cmt_len  <= '0;
      stage    <= '0;
    end else begin
      cmt_stb <= 1'b0;
      if (adr_hit) begin
        wr_act   <= !adr_read;
        have_cmd <= 1'b0;
        bad      <= 1'b0;
        cnt      <= '0;
      end else if (bus_start) begin
        wr_act <= 1'b0;
      end else if (bus_stop) begin
        wr_act <= 1'b0;
        if (wr_act && complete) begin
          cmt_stb <= 1'b1;
          cmt_cmd <= cmd_q;
          cmt_len <= done_len;
        end
      end else if (rx_valid && wr_act) begin
        if (!rx_ack) bad <= 1'b1;
        else if (!have_cmd) begin
          have_cmd <= 1'b1;
          cmd_q    <= rx_data;
          sel_cmd  <= rx_data;
        end else begin
          cnt <= cnt + CW'(1);
          if (kind == K_BLOCK && cnt == '0) blen <= LW'(rx_data);
          else stage[slot] <= rx_data;
        end
      end
    end
  end

  // R7: a commit pulse only ever follows a stop
  p_commit_after_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_stb |-> $past(bus_stop));
  // R5: committed block length within 1..BLK_MAX
  p_block_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_stb && kind_of(cmt_cmd) == K_BLOCK) |-> (cmt_len != '0 && cmt_len <= LW'(BLK_MAX)));
  // R2: a nacked byte never changes the selection
  p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ack && !adr_hit) |=> $stable(sel_cmd));
endmodule

// File: rtl/smbr_regs.sv
module smbr_regs
  import smbr_pkg::*;
#(
  parameter int BYTE_REGS = 8,
  parameter int WORD_REGS = 4,
  parameter int BLK_MAX   = 32,
  localparam int BAW = $clog2(BYTE_REGS),
  localparam int WAW = $clog2(WORD_REGS),
  localparam int LW  = $clog2(BLK_MAX + 1),
  localparam int TW  = $clog2(BLK_MAX + 2),
  localparam int SW  = $clog2(BLK_MAX)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmt_stb,
  input  logic [7:0]              cmt_cmd,
  input  logic [LW-1:0]           cmt_len,
  input  logic [BLK_MAX-1:0][7:0] stage,
  input  logic [7:0]              sel_cmd,
  input  logic [TW-1:0]           rd_idx,
  output logic [7:0]              rd_byte
);
  logic [7:0]             byte_r [BYTE_REGS];
  logic [15:0]            word_r [WORD_REGS];
  logic [BLK_MAX-1:0][7:0] blk_r;
  logic [LW-1:0]          blen_r;
  logic                   unused_cmd_bits;

  assign unused_cmd_bits = ^{cmt_cmd[5:0], sel_cmd[5:0]};

  for (genvar g = 0; g < BYTE_REGS; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_r[g] <= '0;
      else if (cmt_stb && kind_of(cmt_cmd) == K_BYTE && cmt_cmd[BAW-1:0] == BAW'(g))
        byte_r[g] <= stage[0];
    end
  end

  for (genvar g = 0; g < WORD_REGS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_r[g] <= '0;
      else if (cmt_stb && kind_of(cmt_cmd) == K_WORD && cmt_cmd[WAW-1:0] == WAW'(g))
        word_r[g] <= {stage[1], stage[0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_r  <= '0;
      blen_r <= '0;
    end else if (cmt_stb && kind_of(cmt_cmd) == K_BLOCK) begin
      blen_r <= cmt_len;
      for (int i = 0; i < BLK_MAX; i++)
        if (LW'(i) < cmt_len) blk_r[i] <= stage[i];
    end
  end

  always_comb begin
    rd_byte = FILL_BYTE;
    unique case (kind_of(sel_cmd))
      K_BYTE:  if (rd_idx == '0) rd_byte = byte_r[sel_cmd[BAW-1:0]];
      K_WORD: begin
        if (rd_idx == '0)            rd_byte = word_r[sel_cmd[WAW-1:0]][7:0];
        else if (rd_idx == TW'(1))   rd_byte = word_r[sel_cmd[WAW-1:0]][15:8];
      end
      K_BLOCK: begin
        if (rd_idx == '0)                rd_byte = 8'(blen_r);
        else if (rd_idx <= TW'(blen_r))  rd_byte = blk_r[SW'(rd_idx - TW'(1))];
      end
      default: rd_byte = FILL_BYTE;
    endcase
  end

  // R7: storage only moves on a commit pulse
  p_store_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cmt_stb |=> $stable(blen_r));
endmodule

// File: rtl/smbr_rd_path.sv
module smbr_rd_path #(
  parameter int BLK_MAX = 32,
  localparam int TW = $clog2(BLK_MAX + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_start,
  input  logic          bus_stop,
  input  logic          adr_hit,
  input  logic          adr_read,
  input  logic          tx_ready,
  input  logic          hack_valid,
  input  logic          hack_nack,
  output logic          tx_valid,
  output logic [TW-1:0] rd_idx
);
  logic rd_act, quiet;

  assign tx_valid = rd_act && !quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_act <= 1'b0;
      quiet  <= 1'b0;
      rd_idx <= '0;
    end else if (adr_hit) begin
      rd_act <= adr_read;
      quiet  <= 1'b0;
      rd_idx <= '0;
    end else if (bus_start || bus_stop) begin
      rd_act <= 1'b0;
    end else begin
      if (tx_valid && tx_ready && rd_idx != '1) rd_idx <= rd_idx + TW'(1);
      if (hack_valid && hack_nack) quiet <= 1'b1;
    end
  end

  // R11: nothing offered after the host nacks
  p_quiet_after_nack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (hack_valid && hack_nack && !adr_hit) |=> !tx_valid);
  // R11: silence lasts until a new address match
  p_stay_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_valid && !adr_hit) |=> !tx_valid);
endmodule

// File: rtl/smbus_cmd_resp.sv
module smbus_cmd_resp
  import smbr_pkg::*;
#(
  parameter int BYTE_REGS = 8,
  parameter int WORD_REGS = 4,
  parameter int BLK_MAX   = 32,
  localparam int LW = $clog2(BLK_MAX + 1),
  localparam int TW = $clog2(BLK_MAX + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_start,
  input  logic          bus_stop,
  input  logic          adr_hit,
  input  logic          adr_read,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  output logic          rx_ack,
  input  logic          tx_ready,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  input  logic          hack_valid,
  input  logic          hack_nack,
  output logic          wr_stb,
  output logic [7:0]    wr_cmd,
  output logic [LW-1:0] wr_len
);
  logic [7:0]              sel_cmd;
  logic [BLK_MAX-1:0][7:0] stage;
  logic [TW-1:0]           rd_idx;

  smbr_wr_path #(.BLK_MAX(BLK_MAX)) u_wr (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .adr_hit(adr_hit), .adr_read(adr_read), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ack(rx_ack), .sel_cmd(sel_cmd), .cmt_stb(wr_stb), .cmt_cmd(wr_cmd),
    .cmt_len(wr_len), .stage(stage)
  );

  smbr_regs #(.BYTE_REGS(BYTE_REGS), .WORD_REGS(WORD_REGS), .BLK_MAX(BLK_MAX)) u_regs (
    .clk(clk), .rst_n(rst_n), .cmt_stb(wr_stb), .cmt_cmd(wr_cmd), .cmt_len(wr_len),
    .stage(stage), .sel_cmd(sel_cmd), .rd_idx(rd_idx), .rd_byte(tx_data)
  );

  smbr_rd_path #(.BLK_MAX(BLK_MAX)) u_rd (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .adr_hit(adr_hit), .adr_read(adr_read), .tx_ready(tx_ready),
    .hack_valid(hack_valid), .hack_nack(hack_nack), .tx_valid(tx_valid), .rd_idx(rd_idx)
  );

  // R10: offered byte held while the engine stalls
  p_hold_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !bus_start && !bus_stop && !adr_hit && !hack_valid)
      |=> $stable(tx_data));
  // R4: word commits are two bytes long
  p_word_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && kind_of(wr_cmd) == K_WORD) |-> wr_len == LW'(2));
  // R3: byte commits are one byte long
  p_byte_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && kind_of(wr_cmd) == K_BYTE) |-> wr_len == LW'(1));
endmodule

// File: tb/smbus_cmd_resp_tb_top.sv
module smbus_cmd_resp_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_start = 0, bus_stop = 0, adr_hit = 0, adr_read = 0;
  logic rx_valid = 0; logic [7:0] rx_data = '0; logic rx_ack;
  logic tx_ready = 0; logic tx_valid; logic [7:0] tx_data;
  logic hack_valid = 0, hack_nack = 0;
  logic wr_stb; logic [7:0] wr_cmd; logic [5:0] wr_len;

  always #4 clk = ~clk;

  smbus_cmd_resp dut_i (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .adr_hit(adr_hit), .adr_read(adr_read), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ack(rx_ack), .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .hack_valid(hack_valid), .hack_nack(hack_nack), .wr_stb(wr_stb), .wr_cmd(wr_cmd),
    .wr_len(wr_len)
  );

  int checks = 0, fails = 0; bit finished = 0;
  logic [7:0]  m_byte [8];
  logic [15:0] m_word [4];
  logic [7:0]  m_blk  [32];
  int          m_blen;
  logic [7:0]  m_sel;
  logic [7:0]  pay [40];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] sel, input int idx);
    case (sel[7:6])
      2'd0: return (idx == 0) ? m_byte[sel[2:0]] : 8'hFF;
      2'd1: return (idx == 0) ? m_word[sel[1:0]][7:0] : (idx == 1) ? m_word[sel[1:0]][15:8] : 8'hFF;
      2'd2: return (idx == 0) ? 8'(m_blen) : (idx <= m_blen) ? m_blk[idx-1] : 8'hFF;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic pulse_start(); @(negedge clk); bus_start = 1; @(negedge clk); bus_start = 0; endtask
  task automatic pulse_addr(input bit rd);
    @(negedge clk); adr_hit = 1; adr_read = rd; @(negedge clk); adr_hit = 0;
  endtask

  task automatic send_byte(input logic [7:0] d, input bit exp_ack, input string req);
    @(negedge clk); rx_valid = 1; rx_data = d; #1;
    chk(rx_ack === exp_ack, req, "rx_ack", int'(rx_ack), int'(exp_ack));
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic do_stop(input bit exp_stb, input logic [7:0] cmd, input int len, input string req);
    @(negedge clk); bus_stop = 1; @(negedge clk); bus_stop = 0;
    chk(wr_stb === exp_stb, req, "wr_stb", int'(wr_stb), int'(exp_stb));
    if (exp_stb) begin
      chk(wr_cmd === cmd, req, "wr_cmd", int'(wr_cmd), int'(cmd));
      chk(int'(wr_len) == len, req, "wr_len", int'(wr_len), len);
    end
  endtask

  task automatic read_byte(input logic [7:0] exp, input bit last, input string req);
    @(negedge clk); tx_ready = 1; #1;
    chk(tx_valid === 1'b1, req, "tx_valid", int'(tx_valid), 1);
    chk(tx_data === exp, req, "tx_data", int'(tx_data), int'(exp));
    @(negedge clk); tx_ready = 0; hack_valid = 1; hack_nack = last;
    @(negedge clk); hack_valid = 0; hack_nack = 0;
    if (last) begin
      #1 chk(tx_valid === 1'b0, "R11", "tx_valid after nack", int'(tx_valid), 0);
    end
  endtask

  task automatic commit_model(input logic [7:0] cmd);
    case (cmd[7:6])
      2'd0: m_byte[cmd[2:0]] = pay[0];
      2'd1: m_word[cmd[1:0]] = {pay[1], pay[0]};
      2'd2: begin m_blen = int'(pay[0]); for (int i = 0; i < m_blen; i++) m_blk[i] = pay[i+1]; end
      default: ;
    endcase
  endtask

  // n payload bytes from pay[]; end_stop=0 leaves the write for a repeated start
  task automatic wr_txn(input logic [7:0] cmd, input int n, input bit end_stop, input string req);
    bit bad, ok, done, a; int len; logic [1:0] k;
    k = cmd[7:6];
    pulse_start(); pulse_addr(1'b0);
    ok = (k != 2'd3);
    send_byte(cmd, ok, "R2");
    bad = !ok;
    if (ok) m_sel = cmd;
    for (int i = 0; i < n; i++) begin
      if (bad) a = 0;
      else case (k)
        2'd0: a = (i == 0);
        2'd1: a = (i < 2);
        2'd2: a = (i == 0) ? (pay[0] != 0 && pay[0] <= 32) : (i <= int'(pay[0]));
        default: a = 0;
      endcase
      send_byte(pay[i], a, req);
      if (!a) bad = 1;
    end
    len = (k == 2'd0) ? 1 : (k == 2'd1) ? 2 : int'(pay[0]);
    done = !bad && ((k == 2'd0 && n == 1) || (k == 2'd1 && n == 2) ||
                    (k == 2'd2 && n >= 1 && n == int'(pay[0]) + 1));
    if (end_stop) begin
      do_stop(done, cmd, len, done ? req : "R6");
      if (done) commit_model(cmd);
    end
  endtask

  task automatic rd_txn(input bit with_cmd, input logic [7:0] cmd, input int nb, input string req);
    bit ok;
    if (with_cmd) begin
      pulse_start(); pulse_addr(1'b0);
      ok = (cmd[7:6] != 2'd3);
      send_byte(cmd, ok, "R2");
      if (ok) m_sel = cmd;
    end
    pulse_start(); pulse_addr(1'b1);
    for (int i = 0; i < nb; i++) read_byte(exp_rd(m_sel, i), i == nb - 1, req);
    do_stop(1'b0, 8'h00, 0, "R7");
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual running expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7391));
    for (int i = 0; i < 8; i++) m_byte[i] = 0;
    for (int i = 0; i < 4; i++) m_word[i] = 0;
    for (int i = 0; i < 32; i++) m_blk[i] = 0;
    m_blen = 0; m_sel = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1 reset state
    chk(tx_valid === 1'b0, "R1", "tx_valid", int'(tx_valid), 0);
    chk(wr_stb === 1'b0, "R1", "wr_stb", int'(wr_stb), 0);
    // R12 byte with no address
    send_byte(8'h05, 1'b0, "R12");
    rd_txn(1'b0, 8'h00, 1, "R1");
    rd_txn(1'b1, 8'h80, 1, "R1");
    // R3 byte write and readback
    pay[0] = 8'hA5; wr_txn(8'h05, 1, 1'b1, "R3");
    rd_txn(1'b1, 8'h05, 2, "R3");
    pay[0] = 8'h11; pay[1] = 8'h22; wr_txn(8'h05, 2, 1'b1, "R3");
    rd_txn(1'b1, 8'h05, 1, "R3");
    // R4 word
    pay[0] = 8'h34; pay[1] = 8'h12; wr_txn(8'h42, 2, 1'b1, "R4");
    rd_txn(1'b1, 8'h42, 3, "R4");
    // R5 / R9 blocks
    pay[0] = 8'd3; pay[1] = 8'hD0; pay[2] = 8'hD1; pay[3] = 8'hD2; wr_txn(8'h80, 4, 1'b1, "R5");
    rd_txn(1'b1, 8'h80, 5, "R9");
    pay[0] = 8'd0; wr_txn(8'h80, 1, 1'b1, "R5");
    pay[0] = 8'd33; wr_txn(8'h80, 2, 1'b1, "R5");
    pay[0] = 8'd32; for (int i = 1; i < 34; i++) pay[i] = 8'(i * 7);
    wr_txn(8'h80, 34, 1'b1, "R5");
    wr_txn(8'h80, 33, 1'b1, "R5");
    rd_txn(1'b1, 8'h80, 34, "R9");
    pay[0] = 8'd1; pay[1] = 8'h5A; wr_txn(8'h81, 2, 1'b1, "R5");
    rd_txn(1'b0, 8'h00, 3, "R9");
    // R2 reserved command keeps selection
    wr_txn(8'hC3, 0, 1'b1, "R2");
    rd_txn(1'b0, 8'h00, 2, "R2");
    // R6 incomplete word
    pay[0] = 8'hEE; wr_txn(8'h43, 1, 1'b1, "R6");
    rd_txn(1'b1, 8'h43, 2, "R6");
    // R7/R8 write with repeated start, then plain read
    pay[0] = 8'h77; wr_txn(8'h06, 1, 1'b0, "R7");
    rd_txn(1'b0, 8'h00, 1, "R7");
    wr_txn(8'h42, 0, 1'b0, "R8");
    rd_txn(1'b0, 8'h00, 2, "R8");
    // R12 bytes during a read phase
    pulse_start(); pulse_addr(1'b1);
    send_byte(8'h01, 1'b0, "R12");
    // R10 hold while stalled
    repeat (3) @(negedge clk);
    #1 chk(tx_valid === 1'b1 && tx_data === exp_rd(m_sel, 0), "R10", "held tx_data",
           int'(tx_data), int'(exp_rd(m_sel, 0)));
    read_byte(exp_rd(m_sel, 0), 1'b1, "R10");
    do_stop(1'b0, 8'h00, 0, "R12");
    rd_txn(1'b0, 8'h00, 1, "R12");
    // random mix
    for (int it = 0; it < 200; it++) begin
      int op, n; logic [7:0] cmd;
      op = int'($urandom % 6);
      cmd = 8'($urandom);
      case (op)
        0: begin cmd[7:6] = 2'd0; pay[0] = 8'($urandom); pay[1] = 8'($urandom);
                 wr_txn(cmd, ($urandom % 8 == 0) ? 2 : 1, 1'b1, "R3"); end
        1: begin cmd[7:6] = 2'd1; pay[0] = 8'($urandom); pay[1] = 8'($urandom); pay[2] = 8'($urandom);
                 wr_txn(cmd, 1 + int'($urandom % 3), 1'b1, "R4"); end
        2: begin cmd[7:6] = 2'd2; pay[0] = 8'($urandom % 35);
                 for (int i = 1; i < 40; i++) pay[i] = 8'($urandom);
                 n = int'(pay[0]) + 1; if ($urandom % 5 == 0) n = n - 1; if (n > 36) n = 36;
                 wr_txn(cmd, n, 1'b1, "R5"); end
        3: rd_txn(1'b1, cmd, 1 + int'($urandom % 35), "R9");
        4: rd_txn(1'b0, 8'h00, 1 + int'($urandom % 4), "R8");
        default: begin cmd[7:6] = 2'($urandom % 3); pay[0] = 8'($urandom % 4); pay[1] = 8'($urandom);
                 pay[2] = 8'($urandom); wr_txn(cmd, 2, 1'b0, "R7");
                 rd_txn(1'b0, 8'h00, 2, "R7"); end
      endcase
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule